// File: doc/BRIEF.md
# Color Code Serial Transmitter

This block turns a one-cycle load request into a short serial frame for up to four display channels. On an accepted strobe it latches an 8-bit color code and a 4-bit channel mask from a 12-bit data word. It then emits a fixed nine-bit frame: a one-valued start bit, followed by the eight code bits, least significant first. At a 10 MHz clock with one cycle per bit, each bit lasts 100 ns and a frame takes 900 ns. An 8-bit code selects one of 256 colors.

The single serial stream is gated onto each channel output by that channel's mask bit. Unselected channels, and all channels between frames, stay low. The bit time is a parameter counted in clock cycles.

The controller is a three-state machine:
- `ST_IDLE`: waiting. An accepted strobe moves it to `ST_START`.
- `ST_START`: sends the start bit. When the bit timer ends the bit, it moves to `ST_DATA`.
- `ST_DATA`: sends code bits. It returns to `ST_IDLE` when the timer ends the eighth bit.

A strobe seen outside `ST_IDLE` is dropped.

Top module: `color_serial_tx`

## Requirements
- R1: During and straight after reset, `busy_o` is low and every bit of `disp_o` is low.
- R2: A strobe on `load_i` sampled in `ST_IDLE` captures `data_i[7:0]` as the color code and `data_i[11:8]` as the mask, with `data_i[8+i]` selecting channel i. `busy_o` is high from the next cycle.
- R3: The first bit of each frame is a 1 and lasts `CLKS_PER_BIT` cycles.
- R4: After the start bit, code bits go out in order bit 0 through bit 7, each lasting `CLKS_PER_BIT` cycles.
- R5: `busy_o` stays high for exactly 9×`CLKS_PER_BIT` cycles per frame and then falls.
- R6: `disp_o[i]` carries the stream only when captured mask bit i is 1. An unselected channel stays low for the whole frame, including when the mask is zero.
- R7: A strobe sampled while `busy_o` is high has no effect. The frame in flight continues with its original code and mask, and no extra frame follows.
- R8: While `busy_o` is low, all of `disp_o` is low.
- R9: A strobe sampled in the first cycle after `busy_o` falls is accepted and starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | One-cycle frame request strobe |
| data_i | input | 12 | Bits 7:0 color code, bits 11:8 channel mask |
| busy_o | output | 1 | High for the duration of a frame |
| disp_o | output | 4 | Gated serial stream, one bit per display channel |

## Verification
The bench targets the frame edges.
- The last cycle of a frame: a controller that ends one bit late or early shows up as a stretched or missing final bit and a busy flag of the wrong length.
- A strobe in the final busy cycle: a design that accepts it starts a spurious frame.
- A strobe in the first idle cycle: a design that misses it drops a back-to-back frame.
- Codes with a lone set bit at either end: a design that shifts most-significant-first puts the bit at the wrong position.
- A mid-frame strobe carrying different data: a design that overwrites its mask or code corrupts the stream.
- An empty mask: a design that does not gate the channels lets the stream leak onto them.

// File: rtl/ctx_pkg.sv
`timescale 1ns/1ps
package ctx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2
    } ctx_state_e;
endpackage

// File: rtl/ctx_bit_timer.sv
`timescale 1ns/1ps
module ctx_bit_timer #(
    parameter int CLKS_PER_BIT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == LAST);

    // R5: the counter never passes the bit-time limit
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/ctx_shifter.sv
`timescale 1ns/1ps
module ctx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] din_i,
    input  logic         shift_i,
    output logic         lsb_o
);
    logic [W-1:0] sreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sreg_q <= '0;
        else if (load_i)  sreg_q <= din_i;
        else if (shift_i) sreg_q <= {1'b0, sreg_q[W-1:1]};
    end

    assign lsb_o = sreg_q[0];
endmodule

// File: rtl/ctx_steer.sv
`timescale 1ns/1ps
module ctx_steer #(
    parameter int N = 4
) (
    input  logic         serial_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] disp_o
);
    for (genvar i = 0; i < N; i++) begin : g_chan
        assign disp_o[i] = serial_i & mask_i[i];
    end
endmodule

// File: rtl/color_serial_tx.sv
`timescale 1ns/1ps
module color_serial_tx
    import ctx_pkg::*;
#(
    parameter int CODE_W       = 8,
    parameter int NUM_DISP     = 4,
    parameter int CLKS_PER_BIT = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_i,
    input  logic [CODE_W+NUM_DISP-1:0]   data_i,
    output logic                         busy_o,
    output logic [NUM_DISP-1:0]          disp_o
);
    localparam int DIN_W = CODE_W + NUM_DISP;
    localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_W - 1);

    ctx_state_e          state_q, state_d;
    logic [IDX_W-1:0]    bit_idx_q;
    logic [NUM_DISP-1:0] mask_q;
    logic                accept, tick, shift, lsb, serial;

    assign accept = load_i && (state_q == ST_IDLE);
    assign shift  = (state_q == ST_DATA) && tick;

    ctx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(accept),
        .run_i    (state_q != ST_IDLE),
        .tick_o   (tick)
    );

    ctx_shifter #(.W(CODE_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .din_i  (data_i[CODE_W-1:0]),
        .shift_i(shift),
        .lsb_o  (lsb)
    );

    ctx_steer #(.N(NUM_DISP)) u_steer (
        .serial_i(serial),
        .mask_i  (mask_q),
        .disp_o  (disp_o)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_START;
            ST_START: if (tick)   state_d = ST_DATA;
            ST_DATA:  if (tick && bit_idx_q == LAST_IDX) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and captured context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_idx_q <= '0;
            mask_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                bit_idx_q <= '0;
                mask_q    <= data_i[DIN_W-1:CODE_W];
            end else if (shift) begin
                bit_idx_q <= bit_idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy_o = 1'b1;
        serial = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy_o = 1'b0;
            ST_START: serial = 1'b1;
            ST_DATA:  serial = lsb;
            default:  busy_o = 1'b0;
        endcase
    end

    // R2: accepted strobe starts a frame with the mask from the upper data bits
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_o && (mask_q == $past(data_i[DIN_W-1:CODE_W])));
    // R3: the start bit reaches every selected channel
    a_r3_start_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START) |-> (disp_o == mask_q));
    // R5: busy holds until the last data bit ends
    a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && !(tick && bit_idx_q == LAST_IDX)) |=> busy_o);
    // R6: unselected channels stay low
    a_r6_unselected_low: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_o & ~mask_q) == '0);
    // R7: a strobe during a frame leaves the mask alone
    a_r7_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && busy_o) |=> (mask_q == $past(mask_q)));
    // R8: idle outputs are low
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (disp_o == '0));
endmodule

// File: tb/color_serial_tx_test.sv
`timescale 1ns/1ps
module color_serial_tx_test;
    localparam int CPB   = 3;
    localparam int FRAME = 9 * CPB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [11:0] data_i = '0;
    logic        busy_o;
    logic [3:0]  disp_o;

    int checks = 0;
    int fails  = 0;
    bit mon_en = 1'b0;
    bit done   = 1'b0;

    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    color_serial_tx #(.CODE_W(8), .NUM_DISP(4), .CLKS_PER_BIT(CPB)) uut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .data_i(data_i),
        .busy_o(busy_o), .disp_o(disp_o)
    );

    task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s busy/disp actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // driver: requests a frame and queues its expected per-cycle output
    task automatic start_frame(logic [7:0] code, logic [3:0] mask, string tag);
        @(negedge clk);
        load_i = 1'b1;
        data_i = {mask, code};
        for (int j = 0; j < 9; j++) begin
            logic b;
            b = (j == 0) ? 1'b1 : code[j-1];
            for (int c = 0; c < CPB; c++) begin
                exp_q.push_back({1'b1, b ? mask : 4'b0000});
                tag_q.push_back(j == 0 ? {"R3/R6 ", tag} : {"R4/R5/R6 ", tag});
            end
        end
        @(negedge clk);
        load_i = 1'b0;
        data_i = '0;
    endtask

    // a strobe whose frame must never appear
    task automatic poke(logic [7:0] code, logic [3:0] mask);
        @(negedge clk);
        load_i = 1'b1;
        data_i = {mask, code};
        @(negedge clk);
        load_i = 1'b0;
        data_i = '0;
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares each cycle against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_en) begin
                if (exp_q.size() > 0) check(tag_q.pop_front(), {busy_o, disp_o}, exp_q.pop_front());
                else                  check("R5/R8 idle", {busy_o, disp_o}, 5'b0);
            end
        end
    end

    initial begin
        #3;
        check("R1 in reset", {busy_o, disp_o}, 5'b0);
        wait_cycles(3);
        rst_n = 1'b1;
        check("R1 after reset", {busy_o, disp_o}, 5'b0);
        mon_en = 1'b1;
        wait_cycles(2);

        start_frame(8'hA5, 4'b1111, "R2 all");
        wait_cycles(FRAME + 2);
        start_frame(8'h01, 4'b0001, "R4 low bit");
        wait_cycles(FRAME + 2);
        start_frame(8'h80, 4'b1010, "R4 high bit");
        wait_cycles(FRAME + 2);
        start_frame(8'h5A, 4'b0000, "R6 empty mask");
        wait_cycles(FRAME + 2);

        // R7: mid-frame strobe with different data
        start_frame(8'h3C, 4'b0110, "R7 mid");
        wait_cycles(4);
        poke(8'hFF, 4'b1001);
        wait_cycles(FRAME + 2);

        // R7: strobe in the last busy cycle, then R9 in the first idle cycle
        start_frame(8'hC3, 4'b0100, "R7 last");
        wait_cycles(FRAME - 2);
        poke(8'hFF, 4'b1111);
        wait_cycles(FRAME + 2);
        start_frame(8'h96, 4'b1000, "R9 first");
        wait_cycles(FRAME - 1);
        start_frame(8'h69, 4'b0011, "R9 back-to-back");
        wait_cycles(FRAME + 4);

        if (exp_q.size() != 0) begin
            fails++;
            checks++;
            $display("FAIL R5 scoreboard left %0d items, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule